// File: doc/BRIEF.md
# Interleaved Tile Register Store

This block holds a square register array of SVL rows, each SVL bytes wide (SVL is a parameter, 16 by default). Software treats the array as a set of square tiles. The set depends on the element size in use. For an element of N bytes there are N tiles, and consecutive rows of one tile are spread N physical rows apart. A single storage array therefore serves every element size, with no copying between views.

Three commands act on the array. A predicated slice write places a vector into one row (horizontal) or one column (vertical) of a chosen tile. Elements whose predicate bit is clear keep their old value. A slice read is combinational and returns any row or column of any tile as a vector, whatever the predicate. A masked zero command clears physical rows by their index modulo 8. Writes and zeroing commit on the rising clock edge at which their strobe is sampled high.

Top module: `tile_store`

## Requirements
- R1: A synchronous reset clears every byte of the array, so that any read after reset returns all zeros.
- R2: Element size code z from 0 to 4 selects N = 2^z bytes per element. There are N tiles, each SVL/N elements square. The tile index is taken modulo N and the slice index modulo SVL/N.
- R3: A horizontal write with tile t and slice s targets physical row t + N*s. Vector byte j goes to byte j of that row. An element is written only when the predicate bit at its lowest byte is 1. Inactive elements keep their previous contents.
- R4: A vertical write with tile t and column c places element k of the vector (vector bytes k*N to k*N+N-1) into physical row t + N*k, bytes c*N to c*N+N-1. The element is written only when predicate bit k*N is 1.
- R5: A horizontal read returns physical row t + N*s, with row byte j on vector byte j.
- R6: A vertical read returns, as vector element k, bytes c*N to c*N+N-1 of physical row t + N*k. It returns every element, independent of any predicate.
- R7: A zero command clears physical row i when bit (i mod 8) of the 8-bit mask is 1. A mask of 0xFF clears the whole array.
- R8: When a zero and a write commit on the same edge, the zero is applied first and the active elements of the write then override it.
- R9: A write with a size code of 5, 6 or 7 changes nothing. A read with such a code returns all zeros.
- R10: A write or zero changes the read data only after the clock edge that samples it. Reads follow the current contents combinationally. With no command the contents hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Slice write strobe |
| wr_vert | input | 1 | 1 selects a vertical (column) write, 0 a horizontal (row) write |
| wr_esz | input | 3 | Write element size code |
| wr_tile | input | 4 | Write tile index |
| wr_slice | input | log2(SVL) | Write slice (row or column) index within the tile |
| wr_pred | input | SVL | Write predicate, one bit per vector byte |
| wr_data | input | SVL*8 | Write vector, byte j on bits 8j+7:8j |
| zero_en | input | 1 | Zero command strobe |
| zero_mask | input | 8 | Zero mask, bit b selects physical rows with index mod 8 = b |
| rd_vert | input | 1 | 1 selects a vertical read, 0 a horizontal read |
| rd_esz | input | 3 | Read element size code |
| rd_tile | input | 4 | Read tile index |
| rd_slice | input | log2(SVL) | Read slice index within the tile |
| rd_data | output | SVL*8 | Read vector |

## Verification
The hardest case is the aliasing between views. A column written at one element size has to appear, byte for byte, in rows read at a different size, and a partial predicate or a row-modulo zero may have left only part of it intact. A single directed write cannot show this. The stimulus interleaves a long seeded random series of row and column writes at all five sizes with partial predicates, random zero masks and same-cycle zero-plus-write commands. After each command it reads random slices at random sizes, so that bytes written through one view are checked through another. Directed steps cover a full clear, an illegal size code and the value seen before the committing edge.

// File: rtl/tile_store_pkg.sv
package tile_store_pkg;

   // number of supported element sizes: 1, 2, 4, 8 and 16 bytes
   localparam int NUM_SIZES  = 5;
   localparam int MAX_ELEM   = 1 << (NUM_SIZES - 1);
   localparam int TILE_W     = $clog2(MAX_ELEM);
   localparam int ESZ_W      = 3;
   localparam int ZMASK_W    = 8;
   localparam int BYTE_W     = 8;

   typedef enum logic [ESZ_W-1:0] {
      ESZ_B1  = 3'd0,
      ESZ_B2  = 3'd1,
      ESZ_B4  = 3'd2,
      ESZ_B8  = 3'd3,
      ESZ_B16 = 3'd4
   } esz_e;

   function automatic logic esz_legal(input logic [ESZ_W-1:0] code);
      return code <= ESZ_B16;
   endfunction

endpackage

// File: rtl/tile_sel_decode.sv
// Turns a (size, tile, slice) triple into row-index masks shared by the
// write path of every row and by the read multiplexer.
module tile_sel_decode
   import tile_store_pkg::*;
#(
   parameter int SVL   = 16,
   parameter int ROW_W = $clog2(SVL)
) (
   input  logic [ESZ_W-1:0]  esz,
   input  logic [TILE_W-1:0] tile,
   input  logic [ROW_W-1:0]  slice,
   output logic              ok,
   output logic [ROW_W-1:0]  lo_mask,   // N-1: selects the tile within a row group
   output logic [ROW_W-1:0]  tile_m,    // tile index modulo N
   output logic [ROW_W-1:0]  sbase      // (slice modulo SVL/N) * N
);
   localparam logic [ROW_W-1:0] ONE  = ROW_W'(1);
   localparam logic [ROW_W-1:0] ONES = '1;

   logic [ROW_W-1:0] tile_x;
   logic [ROW_W-1:0] slice_m;

   generate
      if (ROW_W > TILE_W) begin : g_tile_ext
         assign tile_x = {{(ROW_W-TILE_W){1'b0}}, tile};
      end else begin : g_tile_same
         assign tile_x = tile[ROW_W-1:0];
      end
   endgenerate

   always_comb begin
      ok      = esz_legal(esz);
      lo_mask = (ONE << esz) - ONE;
      tile_m  = tile_x & lo_mask;
      slice_m = slice & (ONES >> esz);
      sbase   = slice_m << esz;
   end

endmodule

// File: rtl/tile_row_slot.sv
// One physical row of the array: its bytes, its zero decode and the
// per-byte write select for both slice directions.
module tile_row_slot
   import tile_store_pkg::*;
#(
   parameter int SVL     = 16,
   parameter int ROW_IDX = 0,
   parameter int ROW_W   = $clog2(SVL),
   parameter int DW      = SVL * BYTE_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wr_en,
   input  logic               wr_vert,
   input  logic               ok,
   input  logic [ROW_W-1:0]   lo_mask,
   input  logic [ROW_W-1:0]   tile_m,
   input  logic [ROW_W-1:0]   sbase,
   input  logic [SVL-1:0]     wr_pred,
   input  logic [DW-1:0]      wr_data,
   input  logic               zero_en,
   input  logic [ZMASK_W-1:0] zero_mask,
   output logic [DW-1:0]      row_q
);
   localparam logic [ROW_W-1:0] ROW_V  = ROW_W'(ROW_IDX);
   localparam int               ZBIT   = ROW_IDX % ZMASK_W;

   logic in_tile;
   logic wipe;

   // this row belongs to the selected tile when its low bits match
   assign in_tile = (ROW_V & lo_mask) == tile_m;
   assign wipe    = zero_en && zero_mask[ZBIT];

   for (genvar j = 0; j < SVL; j++) begin : g_byte
      localparam logic [ROW_W-1:0] COL_V = ROW_W'(j);

      logic             hit;
      logic [ROW_W-1:0] src;
      logic [ROW_W-1:0] pidx;
      logic             we;

      always_comb begin
         if (wr_vert) begin
            // column slice: element index comes from the row, byte within
            // the element from the column
            hit  = in_tile && ((COL_V & ~lo_mask) == sbase);
            src  = (ROW_V & ~lo_mask) | (COL_V & lo_mask);
            pidx = ROW_V & ~lo_mask;
         end else begin
            hit  = in_tile && ((ROW_V & ~lo_mask) == sbase);
            src  = COL_V;
            pidx = COL_V & ~lo_mask;
         end
      end

      assign we = wr_en && ok && hit && wr_pred[pidx];

      always_ff @(posedge clk) begin
         if (rst) begin
            row_q[j*BYTE_W +: BYTE_W] <= '0;
         end else if (we) begin
            // write overrides a zero on the same edge
            row_q[j*BYTE_W +: BYTE_W] <= wr_data[int'(src)*BYTE_W +: BYTE_W];
         end else if (wipe) begin
            row_q[j*BYTE_W +: BYTE_W] <= '0;
         end
      end
   end

endmodule

// File: rtl/tile_slice_reader.sv
// Combinational gather of one horizontal or vertical slice.
module tile_slice_reader
   import tile_store_pkg::*;
#(
   parameter int SVL   = 16,
   parameter int ROW_W = $clog2(SVL),
   parameter int DW    = SVL * BYTE_W
) (
   input  logic               rd_vert,
   input  logic               ok,
   input  logic [ROW_W-1:0]   lo_mask,
   input  logic [ROW_W-1:0]   tile_m,
   input  logic [ROW_W-1:0]   sbase,
   input  logic [SVL*DW-1:0]  array_q,
   output logic [DW-1:0]      rd_data
);
   for (genvar m = 0; m < SVL; m++) begin : g_out
      localparam logic [ROW_W-1:0] POS_V = ROW_W'(m);

      logic [ROW_W-1:0] row;
      logic [ROW_W-1:0] col;

      always_comb begin
         if (rd_vert) begin
            row = tile_m | (POS_V & ~lo_mask);
            col = sbase  | (POS_V & lo_mask);
         end else begin
            row = tile_m | sbase;
            col = POS_V;
         end
      end

      assign rd_data[m*BYTE_W +: BYTE_W] = ok ?
         array_q[(int'(row)*SVL + int'(col))*BYTE_W +: BYTE_W] : '0;
   end

endmodule

// File: rtl/tile_store.sv
module tile_store
   import tile_store_pkg::*;
#(
   parameter int SVL   = 16,
   parameter int ROW_W = $clog2(SVL),
   parameter int DW    = SVL * BYTE_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wr_en,
   input  logic               wr_vert,
   input  logic [ESZ_W-1:0]   wr_esz,
   input  logic [TILE_W-1:0]  wr_tile,
   input  logic [ROW_W-1:0]   wr_slice,
   input  logic [SVL-1:0]     wr_pred,
   input  logic [DW-1:0]      wr_data,
   input  logic               zero_en,
   input  logic [ZMASK_W-1:0] zero_mask,
   input  logic               rd_vert,
   input  logic [ESZ_W-1:0]   rd_esz,
   input  logic [TILE_W-1:0]  rd_tile,
   input  logic [ROW_W-1:0]   rd_slice,
   output logic [DW-1:0]      rd_data
);
   // elaboration checks on the geometry
   generate
      if (SVL < MAX_ELEM) begin : g_bad_small
         $error("tile_store: SVL must be at least the largest element size");
      end
      if ((SVL & (SVL - 1)) != 0) begin : g_bad_pow2
         $error("tile_store: SVL must be a power of two");
      end
      if (SVL % ZMASK_W != 0) begin : g_bad_zmask
         $error("tile_store: SVL must be a multiple of the zero mask width");
      end
      if (ROW_W != $clog2(SVL) || DW != SVL * BYTE_W) begin : g_bad_derived
         $error("tile_store: derived widths must not be overridden");
      end
   endgenerate

   logic             w_ok, r_ok;
   logic [ROW_W-1:0] w_lo, w_tile, w_sbase;
   logic [ROW_W-1:0] r_lo, r_tile, r_sbase;
   logic [SVL*DW-1:0] array_q;

   tile_sel_decode #(.SVL(SVL), .ROW_W(ROW_W)) u_wdec (
      .esz(wr_esz), .tile(wr_tile), .slice(wr_slice),
      .ok(w_ok), .lo_mask(w_lo), .tile_m(w_tile), .sbase(w_sbase)
   );

   tile_sel_decode #(.SVL(SVL), .ROW_W(ROW_W)) u_rdec (
      .esz(rd_esz), .tile(rd_tile), .slice(rd_slice),
      .ok(r_ok), .lo_mask(r_lo), .tile_m(r_tile), .sbase(r_sbase)
   );

   for (genvar i = 0; i < SVL; i++) begin : g_row
      tile_row_slot #(.SVL(SVL), .ROW_IDX(i), .ROW_W(ROW_W), .DW(DW)) u_row (
         .clk(clk), .rst(rst),
         .wr_en(wr_en), .wr_vert(wr_vert), .ok(w_ok),
         .lo_mask(w_lo), .tile_m(w_tile), .sbase(w_sbase),
         .wr_pred(wr_pred), .wr_data(wr_data),
         .zero_en(zero_en), .zero_mask(zero_mask),
         .row_q(array_q[i*DW +: DW])
      );
   end

   tile_slice_reader #(.SVL(SVL), .ROW_W(ROW_W), .DW(DW)) u_rd (
      .rd_vert(rd_vert), .ok(r_ok),
      .lo_mask(r_lo), .tile_m(r_tile), .sbase(r_sbase),
      .array_q(array_q), .rd_data(rd_data)
   );

endmodule

// File: rtl/tile_store_chk.sv
module tile_store_chk
   import tile_store_pkg::*;
#(
   parameter int SVL   = 16,
   parameter int ROW_W = $clog2(SVL),
   parameter int DW    = SVL * BYTE_W
) (
   input logic               clk,
   input logic               rst,
   input logic               wr_en,
   input logic               wr_vert,
   input logic [ESZ_W-1:0]   wr_esz,
   input logic [TILE_W-1:0]  wr_tile,
   input logic [ROW_W-1:0]   wr_slice,
   input logic [SVL-1:0]     wr_pred,
   input logic [DW-1:0]      wr_data,
   input logic               zero_en,
   input logic [ZMASK_W-1:0] zero_mask,
   input logic               rd_vert,
   input logic [ESZ_W-1:0]   rd_esz,
   input logic [TILE_W-1:0]  rd_tile,
   input logic [ROW_W-1:0]   rd_slice,
   input logic [DW-1:0]      rd_data
);
   logic [ESZ_W+TILE_W+ROW_W:0] rsel;
   assign rsel = {rd_vert, rd_esz, rd_tile, rd_slice};

   // R1: first cycle after reset reads all zeros
   a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> rd_data == '0);

   // R7: full-mask zero without a write empties every slice
   a_r7_full_zero: assert property (@(posedge clk) disable iff (rst)
      $past(zero_en && zero_mask == 8'hFF && !wr_en) |-> rd_data == '0);

   // R3, R5: fully predicated row write reads back through the same row
   a_r3_row_readback: assert property (@(posedge clk) disable iff (rst)
      ($past(wr_en && !wr_vert && (&wr_pred) && esz_legal(wr_esz)) && !rd_vert
       && rd_esz == $past(wr_esz) && rd_tile == $past(wr_tile)
       && rd_slice == $past(wr_slice)) |-> rd_data == $past(wr_data));

   // R4, R6: fully predicated column write reads back through the same column
   a_r4_col_readback: assert property (@(posedge clk) disable iff (rst)
      ($past(wr_en && wr_vert && (&wr_pred) && esz_legal(wr_esz)) && rd_vert
       && rd_esz == $past(wr_esz) && rd_tile == $past(wr_tile)
       && rd_slice == $past(wr_slice)) |-> rd_data == $past(wr_data));

   // R9: illegal size write leaves the contents alone
   a_r9_bad_size_ignored: assert property (@(posedge clk) disable iff (rst)
      ($past(wr_en && !esz_legal(wr_esz) && !zero_en) && $stable(rsel))
      |-> $stable(rd_data));

   // R9: illegal size read is zero
   a_r9_bad_size_read: assert property (@(posedge clk) disable iff (rst)
      !esz_legal(rd_esz) |-> rd_data == '0);

   // R10: with no command the observed slice holds
   a_r10_hold: assert property (@(posedge clk) disable iff (rst)
      ($past(!wr_en && !zero_en) && $stable(rsel)) |-> $stable(rd_data));

endmodule

bind tile_store tile_store_chk #(.SVL(SVL), .ROW_W(ROW_W), .DW(DW)) u_chk (
   .clk(clk), .rst(rst), .wr_en(wr_en), .wr_vert(wr_vert), .wr_esz(wr_esz),
   .wr_tile(wr_tile), .wr_slice(wr_slice), .wr_pred(wr_pred),
   .wr_data(wr_data), .zero_en(zero_en), .zero_mask(zero_mask),
   .rd_vert(rd_vert), .rd_esz(rd_esz), .rd_tile(rd_tile),
   .rd_slice(rd_slice), .rd_data(rd_data)
);

// File: tb/tile_store_test.sv
`timescale 1ns/1ps
module tile_store_test;
   localparam int SVL   = 16;
   localparam int ROW_W = $clog2(SVL);
   localparam int DW    = SVL * 8;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           wr_en = 0, wr_vert = 0, zero_en = 0, rd_vert = 0;
   logic [2:0]     wr_esz = 0, rd_esz = 0;
   logic [3:0]     wr_tile = 0, rd_tile = 0;
   logic [ROW_W-1:0] wr_slice = 0, rd_slice = 0;
   logic [SVL-1:0] wr_pred = 0;
   logic [DW-1:0]  wr_data = 0;
   logic [7:0]     zero_mask = 0;
   logic [DW-1:0]  rd_data;

   int n_run = 0, n_fail = 0;
   bit finished = 0;
   logic [7:0] mdl [SVL][SVL];

   always #2.5 clk = ~clk;

   tile_store #(.SVL(SVL)) uut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_vert(wr_vert), .wr_esz(wr_esz),
      .wr_tile(wr_tile), .wr_slice(wr_slice), .wr_pred(wr_pred),
      .wr_data(wr_data), .zero_en(zero_en), .zero_mask(zero_mask),
      .rd_vert(rd_vert), .rd_esz(rd_esz), .rd_tile(rd_tile),
      .rd_slice(rd_slice), .rd_data(rd_data)
   );

   function automatic logic [DW-1:0] rnd_vec();
      logic [DW-1:0] v;
      for (int i = 0; i < DW/32; i++) v[i*32 +: 32] = $urandom;
      return v;
   endfunction

   // expected slice from the bench model
   function automatic logic [DW-1:0] exp_rd(input bit vert, input int esz,
                                            input int tile, input int sl);
      logic [DW-1:0] o = '0;
      int n, t, s;
      if (esz > 4) return o;
      n = 1 << esz; t = tile % n; s = sl % (SVL / n);
      if (!vert) begin
         for (int j = 0; j < SVL; j++) o[j*8 +: 8] = mdl[t + n*s][j];
      end else begin
         for (int k = 0; k < SVL/n; k++)
            for (int b = 0; b < n; b++)
               o[(k*n+b)*8 +: 8] = mdl[t + n*k][s*n + b];
      end
      return o;
   endfunction

   task automatic model_write(input bit vert, input int esz, input int tile,
                              input int sl, input logic [SVL-1:0] p,
                              input logic [DW-1:0] d);
      int n, t, s;
      if (esz > 4) return;
      n = 1 << esz; t = tile % n; s = sl % (SVL / n);
      if (!vert) begin
         for (int j = 0; j < SVL; j++)
            if (p[(j/n)*n]) mdl[t + n*s][j] = d[j*8 +: 8];
      end else begin
         for (int k = 0; k < SVL/n; k++)
            if (p[k*n])
               for (int b = 0; b < n; b++)
                  mdl[t + n*k][s*n + b] = d[(k*n+b)*8 +: 8];
      end
   endtask

   task automatic model_zero(input logic [7:0] m);
      for (int i = 0; i < SVL; i++)
         if (m[i % 8]) for (int j = 0; j < SVL; j++) mdl[i][j] = 8'h00;
   endtask

   task automatic check(input string req, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cmd(input bit we, input bit vert, input int esz, input int tile,
                      input int sl, input logic [SVL-1:0] p,
                      input logic [DW-1:0] d, input bit ze, input logic [7:0] zm);
      @(negedge clk);
      wr_en = we; wr_vert = vert; wr_esz = 3'(esz); wr_tile = 4'(tile);
      wr_slice = ROW_W'(sl); wr_pred = p; wr_data = d;
      zero_en = ze; zero_mask = zm;
      @(posedge clk); #1;
      wr_en = 0; zero_en = 0;
      if (ze) model_zero(zm);               // R8: zero before write
      if (we) model_write(vert, esz, tile, sl, p, d);
   endtask

   task automatic rd_chk(input bit vert, input int esz, input int tile,
                         input int sl, input string req);
      rd_vert = vert; rd_esz = 3'(esz); rd_tile = 4'(tile); rd_slice = ROW_W'(sl);
      #1;
      check(req, rd_data, exp_rd(vert, esz, tile, sl));
   endtask

   task automatic dump_chk(input string req);
      for (int r = 0; r < SVL; r++) rd_chk(0, 0, 0, r, req);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] d;
      void'($urandom(32'd1234));
      for (int i = 0; i < SVL; i++) for (int j = 0; j < SVL; j++) mdl[i][j] = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 0;

      // R1: reset state, viewed at several sizes
      dump_chk("R1");
      rd_chk(1, 3, 1, 1, "R1");

      // R3, R5: fill every row at byte size
      for (int r = 0; r < SVL; r++) begin
         cmd(1, 0, 0, 0, r, '1, rnd_vec(), 0, 8'h00);
         rd_chk(0, 0, 0, r, "R3 R5");
      end

      // R4, R6: 16-byte column write lands as one element, read across views
      d = rnd_vec();
      cmd(1, 1, 4, 7, 0, '1, d, 0, 8'h00);
      rd_chk(1, 4, 7, 0, "R4 R6");
      rd_chk(0, 0, 0, 7, "R4 R6");
      check("R4", rd_data, d);

      // R2: tile and slice taken modulo (esz 2: tile 5 -> 1, slice 6 -> 2)
      cmd(1, 0, 2, 5, 6, '1, rnd_vec(), 0, 8'h00);
      rd_chk(0, 2, 1, 2, "R2");
      rd_chk(0, 0, 0, 9, "R2");

      // R3: partial predicate, only the lowest byte of each element counts
      cmd(1, 0, 1, 1, 3, 16'h5a5a, rnd_vec(), 0, 8'h00);
      rd_chk(0, 1, 1, 3, "R3");
      cmd(1, 1, 2, 3, 1, 16'h0f01, rnd_vec(), 0, 8'h00);
      rd_chk(1, 2, 3, 1, "R4");
      dump_chk("R4");

      // R10: not visible before the edge, visible after
      d = rnd_vec();
      rd_vert = 0; rd_esz = 0; rd_tile = 0; rd_slice = 4'd2;
      @(negedge clk);
      wr_en = 1; wr_vert = 0; wr_esz = 0; wr_tile = 0; wr_slice = 4'd2;
      wr_pred = '1; wr_data = d;
      #1; check("R10", rd_data, exp_rd(0, 0, 0, 2));
      @(posedge clk); #1; wr_en = 0;
      model_write(0, 0, 0, 2, '1, d);
      check("R10", rd_data, d);

      // R9: illegal size write does nothing, illegal size read is zero
      cmd(1, 0, 5, 0, 0, '1, rnd_vec(), 0, 8'h00);
      cmd(1, 1, 7, 2, 1, '1, rnd_vec(), 0, 8'h00);
      dump_chk("R9");
      rd_chk(0, 6, 0, 0, "R9");
      check("R9", rd_data, '0);

      // R7: partial mask clears rows by index mod 8
      cmd(0, 0, 0, 0, 0, '0, '0, 1, 8'h24);
      dump_chk("R7");

      // R8: full zero with a row write on the same edge
      d = rnd_vec();
      cmd(1, 0, 0, 0, 11, '1, d, 1, 8'hFF);
      dump_chk("R8");
      rd_chk(0, 0, 0, 11, "R8");
      check("R8", rd_data, d);

      // R7: full clear
      cmd(0, 0, 0, 0, 0, '0, '0, 1, 8'hFF);
      dump_chk("R7");

      // random mix of views, predicates and zero masks
      for (int it = 0; it < 600; it++) begin
         int r, esz;
         bit we, ze;
         logic [SVL-1:0] p;
         r   = $urandom % 10;
         esz = (r < 8) ? r % 5 : 5 + r % 3;
         we  = ($urandom % 8) != 0;
         ze  = ($urandom % 6) == 0;
         p   = ($urandom % 2) ? '1 : SVL'($urandom);
         cmd(we, 1'($urandom), esz, $urandom % 16, $urandom % SVL, p, rnd_vec(),
             ze, ($urandom % 5 == 0) ? 8'hFF : 8'($urandom));
         for (int q = 0; q < 3; q++) begin
            bit v = 1'($urandom);
            rd_chk(v, $urandom % 5, $urandom % 16, $urandom % SVL,
                   v ? "R6 random" : "R5 random");
         end
      end
      dump_chk("R3 R4 R7 final");

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule